// File: doc/BRIEF.md
# Exception Return Address Register Unit

This block keeps the address at which the processor resumes after an exception, an interrupt or a privileged call, together with a one-bit privileged-mode flag. Three agents can load it. The exception logic loads it when an event is reported: a precise event captures the faulting PC, and an imprecise event or an interrupt captures the PC that would have issued next. The privileged-call path loads the PC after the call instruction. Software loads it through a plain write port. If more than one writer acts in the same cycle, a fixed priority picks one of them.

A return-from-exception request reads the stored value and presents a fetch redirect one cycle later. The redirect carries the PC and the mode that bit 0 selects. The unit also holds a 7-bit arithmetic-trap summary. It collects trap flags as they arrive and keeps them until software writes the summary.

All pins are plain control and data pins with no back-pressure. The redirect is a one-cycle pulse that the fetch unit must take in the cycle it appears. The block never stalls a writer, and every write request is resolved in the cycle it is presented.

Top module: `exc_return_unit`

## Requirements
- R1: After reset, `addr_rd` is zero, `sum_rd` is zero and `ret_valid` is low.
- R2: A precise exception (`exc_valid`=1, `exc_precise`=1) loads `exc_fault_pc[63:2]` into bits 63:2 of `addr_rd` on the next clock, and loads `exc_cur_priv` into bit 0.
- R3: An imprecise exception or interrupt (`exc_valid`=1, `exc_precise`=0) loads `exc_next_pc[63:2]` into bits 63:2 on the next clock, and loads `exc_cur_priv` into bit 0.
- R4: A privileged-call completion (`call_valid`=1) that no other writer overrides loads `call_next_pc[63:2]` into bits 63:2 and sets bit 0 to 1.
- R5: A software write (`sw_wr_en`=1) loads `sw_wr_data[63:2]` and `sw_wr_data[0]`. Bit 1 of `addr_rd` always reads 0, whatever is written.
- R6: When `exc_valid` is set, the exception value is stored even if a software write or a call completion happens in the same cycle.
- R7: When a software write and a call completion happen in the same cycle without an exception, the software value is stored.
- R8: A `ret_req` in cycle N drives `ret_valid` high in cycle N+1 only. In that cycle `ret_pc` = {stored bits 63:2, 2'b00} and `ret_priv` = stored bit 0, both taken from the value held in cycle N, before any write in cycle N.
- R9: Each summary bit is set on the clock after its `trap_flags` bit is 1, and it stays set while `sum_wr_en` is 0. `sum_rd[0]` is summary bit 10 and `sum_rd[6]` is bit 16.
- R10: A summary write (`sum_wr_en`=1) clears every summary bit, except that bits whose trap flag is 1 in that same cycle end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception or interrupt reported this cycle |
| exc_precise | input | 1 | 1 = precise exception, 0 = imprecise or interrupt |
| exc_fault_pc | input | 64 | PC of the faulting instruction |
| exc_next_pc | input | 64 | PC of the next instruction that would have issued |
| exc_cur_priv | input | 1 | Privileged mode active when the event occurs |
| call_valid | input | 1 | Privileged call completes this cycle |
| call_next_pc | input | 64 | PC after the call instruction |
| sw_wr_en | input | 1 | Software write of the return address |
| sw_wr_data | input | 64 | Software write data |
| addr_rd | output | 64 | Stored value: PC in 63:2, 0 in bit 1, mode in bit 0 |
| ret_req | input | 1 | Return-from-exception request |
| ret_valid | output | 1 | Redirect valid, one-cycle pulse |
| ret_pc | output | 64 | Redirect target PC |
| ret_priv | output | 1 | Mode to resume in (1 = privileged) |
| trap_flags | input | 7 | Arithmetic trap flags for summary bits 16:10 |
| sum_wr_en | input | 1 | Write to the summary, clears it |
| sum_rd | output | 7 | Summary bits 16:10 |

## Verification
The bench drives all three writers in the same cycle and checks that the exception value is stored, because a wrong priority stores the software or call value there. It sends imprecise events to catch a design that always picks the faulting PC, and it writes ones into bit 1 to catch a register that keeps that bit. It puts a return request in the same cycle as a write, because a design that forwards the new value would redirect to the wrong address. It raises trap flags in the same cycle as a summary clear, because a design that gives the clear priority would lose those traps.

// File: rtl/exc_ret_pkg.sv
package exc_ret_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXC  = 2'd1,
    SRC_SW   = 2'd2,
    SRC_CALL = 2'd3
  } wr_src_e;
endpackage

// File: rtl/exc_ret_addr_reg.sv
module exc_ret_addr_reg
  import exc_ret_pkg::*;
#(
  parameter int PC_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_valid,
  input  logic            exc_precise,
  input  logic [PC_W-1:0] exc_fault_pc,
  input  logic [PC_W-1:0] exc_next_pc,
  input  logic            exc_cur_priv,
  input  logic            call_valid,
  input  logic [PC_W-1:0] call_next_pc,
  input  logic            sw_wr_en,
  input  logic [PC_W-1:0] sw_wr_data,
  output logic [PC_W-1:2] pc_q,
  output logic            priv_q
);
  wr_src_e          src;
  logic [PC_W-1:2]  nxt_pc;
  logic             nxt_priv;

  // exception > software > call
  always_comb begin
    if (exc_valid)       src = SRC_EXC;
    else if (sw_wr_en)   src = SRC_SW;
    else if (call_valid) src = SRC_CALL;
    else                 src = SRC_NONE;
  end

  always_comb begin
    nxt_pc   = pc_q;
    nxt_priv = priv_q;
    unique case (src)
      SRC_EXC: begin
        nxt_pc   = exc_precise ? exc_fault_pc[PC_W-1:2] : exc_next_pc[PC_W-1:2];
        nxt_priv = exc_cur_priv;
      end
      SRC_SW: begin
        nxt_pc   = sw_wr_data[PC_W-1:2];
        nxt_priv = sw_wr_data[0];
      end
      SRC_CALL: begin
        nxt_pc   = call_next_pc[PC_W-1:2];
        nxt_priv = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      priv_q <= 1'b0;
    end else begin
      pc_q   <= nxt_pc;
      priv_q <= nxt_priv;
    end
  end
endmodule

// File: rtl/exc_ret_redirect.sv
module exc_ret_redirect #(
  parameter int PC_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ret_req,
  input  logic [PC_W-1:2] pc_q,
  input  logic            priv_q,
  output logic            ret_valid,
  output logic [PC_W-1:0] ret_pc,
  output logic            ret_priv
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_valid <= 1'b0;
      ret_pc    <= '0;
      ret_priv  <= 1'b0;
    end else begin
      ret_valid <= ret_req;
      if (ret_req) begin
        ret_pc   <= {pc_q, 2'b00};
        ret_priv <= priv_q;
      end
    end
  end
endmodule

// File: rtl/exc_ret_trap_sum.sv
module exc_ret_trap_sum #(
  parameter int SUM_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] trap_flags,
  input  logic             sum_wr_en,
  output logic [SUM_W-1:0] sum_q
);
  for (genvar b = 0; b < SUM_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          sum_q[b] <= 1'b0;
      else if (sum_wr_en)  sum_q[b] <= trap_flags[b];
      else                 sum_q[b] <= sum_q[b] | trap_flags[b];
    end
  end
endmodule

// File: rtl/exc_return_unit.sv
module exc_return_unit #(
  parameter int PC_W   = 64,
  parameter int SUM_LO = 10,
  parameter int SUM_HI = 16,
  localparam int SUM_W = SUM_HI - SUM_LO + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_valid,
  input  logic             exc_precise,
  input  logic [PC_W-1:0]  exc_fault_pc,
  input  logic [PC_W-1:0]  exc_next_pc,
  input  logic             exc_cur_priv,
  input  logic             call_valid,
  input  logic [PC_W-1:0]  call_next_pc,
  input  logic             sw_wr_en,
  input  logic [PC_W-1:0]  sw_wr_data,
  output logic [PC_W-1:0]  addr_rd,
  input  logic             ret_req,
  output logic             ret_valid,
  output logic [PC_W-1:0]  ret_pc,
  output logic             ret_priv,
  input  logic [SUM_W-1:0] trap_flags,
  input  logic             sum_wr_en,
  output logic [SUM_W-1:0] sum_rd
);
  logic [PC_W-1:2] pc_q;
  logic            priv_q;

  exc_ret_addr_reg #(.PC_W(PC_W)) addr_i (
    .clk(clk), .rst_n(rst_n),
    .exc_valid(exc_valid), .exc_precise(exc_precise),
    .exc_fault_pc(exc_fault_pc), .exc_next_pc(exc_next_pc),
    .exc_cur_priv(exc_cur_priv),
    .call_valid(call_valid), .call_next_pc(call_next_pc),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .pc_q(pc_q), .priv_q(priv_q)
  );

  assign addr_rd = {pc_q, 1'b0, priv_q};

  exc_ret_redirect #(.PC_W(PC_W)) redir_i (
    .clk(clk), .rst_n(rst_n), .ret_req(ret_req),
    .pc_q(pc_q), .priv_q(priv_q),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_priv(ret_priv)
  );

  exc_ret_trap_sum #(.SUM_W(SUM_W)) sum_i (
    .clk(clk), .rst_n(rst_n), .trap_flags(trap_flags),
    .sum_wr_en(sum_wr_en), .sum_q(sum_rd)
  );
endmodule

// File: rtl/exc_return_unit_chk.sv
module exc_return_unit_chk #(
  parameter int PC_W  = 64,
  parameter int SUM_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exc_valid,
  input logic             exc_precise,
  input logic [PC_W-1:0]  exc_fault_pc,
  input logic [PC_W-1:0]  exc_next_pc,
  input logic             exc_cur_priv,
  input logic             call_valid,
  input logic [PC_W-1:0]  call_next_pc,
  input logic             sw_wr_en,
  input logic [PC_W-1:0]  sw_wr_data,
  input logic [PC_W-1:0]  addr_rd,
  input logic             ret_req,
  input logic             ret_valid,
  input logic [PC_W-1:0]  ret_pc,
  input logic             ret_priv,
  input logic [SUM_W-1:0] trap_flags,
  input logic             sum_wr_en,
  input logic [SUM_W-1:0] sum_rd
);
  // R2
  precise_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && exc_precise |=> addr_rd[PC_W-1:2] == $past(exc_fault_pc[PC_W-1:2])
                                 && addr_rd[0] == $past(exc_cur_priv));
  // R3
  imprecise_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && !exc_precise |=> addr_rd[PC_W-1:2] == $past(exc_next_pc[PC_W-1:2]));
  // R4
  call_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid && !exc_valid && !sw_wr_en |=> addr_rd[PC_W-1:2] == $past(call_next_pc[PC_W-1:2])
                                              && addr_rd[0]);
  // R5
  bit1_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) addr_rd[1] == 1'b0);
  // R7
  sw_over_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en && !exc_valid |=> addr_rd[PC_W-1:2] == $past(sw_wr_data[PC_W-1:2])
                               && addr_rd[0] == $past(sw_wr_data[0]));
  // R8
  ret_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |=> ret_valid && ret_pc == {$past(addr_rd[PC_W-1:2]), 2'b00}
                && ret_priv == $past(addr_rd[0]));
  // R8
  ret_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_req |=> !ret_valid);
  // R9
  sum_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_wr_en |=> (sum_rd & $past(sum_rd)) == $past(sum_rd));
  // R10
  trap_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sum_rd & $past(trap_flags)) == $past(trap_flags));
endmodule

bind exc_return_unit exc_return_unit_chk #(.PC_W(PC_W), .SUM_W(SUM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_precise(exc_precise),
  .exc_fault_pc(exc_fault_pc), .exc_next_pc(exc_next_pc), .exc_cur_priv(exc_cur_priv),
  .call_valid(call_valid), .call_next_pc(call_next_pc),
  .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .addr_rd(addr_rd),
  .ret_req(ret_req), .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_priv(ret_priv),
  .trap_flags(trap_flags), .sum_wr_en(sum_wr_en), .sum_rd(sum_rd)
);

// File: tb/exc_return_unit_tb_top.sv
module exc_return_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W  = 64;
  localparam int SUM_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_valid = 0, exc_precise = 0, exc_cur_priv = 0;
  logic [PC_W-1:0] exc_fault_pc = '0, exc_next_pc = '0, call_next_pc = '0, sw_wr_data = '0;
  logic call_valid = 0, sw_wr_en = 0, ret_req = 0, sum_wr_en = 0;
  logic [SUM_W-1:0] trap_flags = '0;
  logic [PC_W-1:0] addr_rd, ret_pc;
  logic ret_valid, ret_priv;
  logic [SUM_W-1:0] sum_rd;

  int n_run = 0;
  int n_fail = 0;

  logic [PC_W-1:0]  m_addr = '0;
  logic [SUM_W-1:0] m_sum = '0;
  logic             m_rv = 0;
  logic [PC_W-1:0]  m_rpc = '0;
  logic             m_rpriv = 0;
  string            addr_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_return_unit dut_i (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_precise(exc_precise),
    .exc_fault_pc(exc_fault_pc), .exc_next_pc(exc_next_pc), .exc_cur_priv(exc_cur_priv),
    .call_valid(call_valid), .call_next_pc(call_next_pc),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .addr_rd(addr_rd),
    .ret_req(ret_req), .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_priv(ret_priv),
    .trap_flags(trap_flags), .sum_wr_en(sum_wr_en), .sum_rd(sum_rd)
  );

  function automatic logic [PC_W-1:0] next_addr(logic [PC_W-1:0] cur);
    if (exc_valid)
      return {(exc_precise ? exc_fault_pc[PC_W-1:2] : exc_next_pc[PC_W-1:2]), 1'b0, exc_cur_priv};
    if (sw_wr_en)   return {sw_wr_data[PC_W-1:2], 1'b0, sw_wr_data[0]};
    if (call_valid) return {call_next_pc[PC_W-1:2], 2'b01};
    return cur;
  endfunction

  function automatic string pick_tag();
    if (exc_valid && (sw_wr_en || call_valid)) return "R6";
    if (exc_valid) return exc_precise ? "R2" : "R3";
    if (sw_wr_en && call_valid) return "R7";
    if (sw_wr_en) return "R5";
    if (call_valid) return "R4";
    return "R9";
  endfunction

  function automatic logic [SUM_W-1:0] next_sum(logic [SUM_W-1:0] cur);
    return sum_wr_en ? trap_flags : (cur | trap_flags);
  endfunction

  task automatic chk(string tag, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk(addr_tag, addr_rd, m_addr);
    chk(sum_wr_en ? "R10" : "R9", {{(PC_W-SUM_W){1'b0}}, sum_rd}, {{(PC_W-SUM_W){1'b0}}, m_sum});
    chk("R8", {{(PC_W-1){1'b0}}, ret_valid}, {{(PC_W-1){1'b0}}, m_rv});
    if (m_rv) begin
      chk("R8", ret_pc, m_rpc);
      chk("R8", {{(PC_W-1){1'b0}}, ret_priv}, {{(PC_W-1){1'b0}}, m_rpriv});
    end
  endtask

  // inputs are already driven (after a negedge); advance one cycle, then check
  task automatic cycle();
    logic [PC_W-1:0]  na;
    logic [SUM_W-1:0] ns;
    na = next_addr(m_addr);
    ns = next_sum(m_sum);
    addr_tag = pick_tag();
    if (addr_tag == "R9") addr_tag = "R5";
    m_rv = ret_req;
    if (ret_req) begin
      m_rpc   = {m_addr[PC_W-1:2], 2'b00};
      m_rpriv = m_addr[0];
    end
    @(posedge clk);
    m_addr = na;
    m_sum  = ns;
    @(negedge clk);
    check_all();
  endtask

  task automatic idle();
    exc_valid = 0; call_valid = 0; sw_wr_en = 0; ret_req = 0;
    sum_wr_en = 0; trap_flags = '0;
  endtask

  function automatic logic [PC_W-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", addr_rd, '0);
    chk("R1", {{(PC_W-SUM_W){1'b0}}, sum_rd}, '0);
    chk("R1", {{(PC_W-1){1'b0}}, ret_valid}, '0);

    // R5: bit 1 written as one must read zero
    idle(); sw_wr_en = 1; sw_wr_data = 64'hFFFF_0000_1234_5677; cycle();
    // R6: all three writers at once, imprecise
    idle(); exc_valid = 1; exc_precise = 0; exc_next_pc = 64'h0000_0000_0040_1004;
    exc_fault_pc = 64'h1111_1111_1111_1110; exc_cur_priv = 0;
    sw_wr_en = 1; sw_wr_data = 64'h2222_2222_2222_2221;
    call_valid = 1; call_next_pc = 64'h3333_3333_3333_3330; cycle();
    // R7: software beats call
    idle(); sw_wr_en = 1; sw_wr_data = 64'hABCD_0000_0000_1000;
    call_valid = 1; call_next_pc = 64'h0000_0000_0000_8888; cycle();
    // R4: call alone sets privileged flag
    idle(); call_valid = 1; call_next_pc = 64'h0000_0000_0000_2004; cycle();
    // R8: return request with same-cycle write uses old value
    idle(); ret_req = 1; exc_valid = 1; exc_precise = 1;
    exc_fault_pc = 64'h0000_0000_0000_9000; exc_cur_priv = 0; cycle();
    idle(); cycle();
    // R10: clear with a new flag in the same cycle
    idle(); trap_flags = 7'b1010101; cycle();
    idle(); sum_wr_en = 1; trap_flags = 7'b0000010; cycle();
    idle(); cycle();

    for (int i = 0; i < 3000; i++) begin
      idle();
      exc_valid    = ($urandom_range(0, 4) == 0);
      exc_precise  = $urandom_range(0, 1);
      exc_cur_priv = $urandom_range(0, 1);
      exc_fault_pc = rnd64();
      exc_next_pc  = rnd64();
      call_valid   = ($urandom_range(0, 4) == 0);
      call_next_pc = rnd64();
      sw_wr_en     = ($urandom_range(0, 4) == 0);
      sw_wr_data   = rnd64();
      ret_req      = ($urandom_range(0, 2) == 0);
      sum_wr_en    = ($urandom_range(0, 6) == 0);
      for (int b = 0; b < SUM_W; b++) trap_flags[b] = ($urandom_range(0, 9) == 0);
      cycle();
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule